// File: doc/BRIEF.md
# Shared Handshake Pin Controller

This block owns three package pins that are each shared between an auxiliary-processor bus handshake, a chip select and a UART modem handshake line. A pin-function register picks, per pin, which of the three functions the pin carries. Pin A is an output carrying a bus request, a chip select or request-to-send. Pin B is bidirectional at the pad: it takes in a bus acknowledge or data-set-ready, or it drives a chip select. Pin C is an output carrying a shared-memory drive strobe, a chip select or data-terminal-ready. Every one of these functions is active low.

Beside the pin multiplexing, the block holds the modem control bits (DTR, RTS, loop) and produces modem status. That status is the inverted, synchronized DSR level and a sticky delta flag that raises a modem status interrupt when it is enabled. A CPU reaches the four registers through a plain address/strobe port with combinational read data. Reading the status register clears the delta flag. The chip-select decoding, the bus arbitration logic and the UART datapath sit outside and connect through the `*_i` inputs.

Top module: `modem_pin_mux`

## Requirements
- R1: Register 3 selects pin functions: bits [1:0] for pin A, [3:2] for pin B, [5:4] for pin C. Code 00 selects the bus handshake function, 01 selects the chip select, and 10 or 11 select the modem function.
- R2: Pin A drives `bus_req_n_i` in bus mode and `cs_n_i[0]` in chip-select mode. In modem mode it drives the inverse of register 0 bit 2 (RTS), so writing 1 drives the pin low.
- R3: Pin C drives `drv_n_i` in bus mode and `cs_n_i[2]` in chip-select mode. In modem mode it drives the inverse of register 0 bit 0 (DTR).
- R4: Pin B enables its pad driver only in chip-select mode, and then drives `cs_n_i[1]`. Otherwise `pad_b_oe` is 0 and `pad_b_o` is 1. `bus_ack_n_o` follows `pad_b_i` in bus mode and is 1 in the other modes.
- R5: While register 0 bit 4 (loop) is 1, pins A and C in modem mode are held high whatever the RTS and DTR bits are. Pins in the other modes are not affected.
- R6: Reset asserts asynchronously and clears every register. After reset all pins are in bus mode, and RTS and DTR are at their inactive high level once modem mode is selected.
- R7: Register 1 bit 5 reads as the complement of `pad_b_i` two clock edges after the pad changes, while pin B is in modem mode. In other modes it reads 0.
- R8: Register 1 bit 1 (delta DSR) is set on the third clock edge after `pad_b_i` changes while pin B is in modem mode. Pad changes in other modes are ignored, and entering modem mode sets no delta.
- R9: A read of register 1 clears delta DSR at the end of the read cycle. A DSR change detected in that same cycle leaves it set.
- R10: `msi_irq` is 1 exactly while delta DSR and register 2 bit 0 are both 1, and it stays asserted until the delta is cleared.
- R11: Registers 0, 2 and 3 read back the full byte last written. Register 1 ignores writes, and its bits other than 1 and 5 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (side effect on register 1) |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr` (combinational) |
| bus_req_n_i | input | 1 | Bus request from the auxiliary bus logic |
| cs_n_i | input | 3 | Chip selects from the address decoder, one per pin |
| drv_n_i | input | 1 | Shared-memory drive strobe |
| pad_a_o | output | 1 | Pin A output |
| pad_b_i | input | 1 | Pin B pad input |
| pad_b_o | output | 1 | Pin B pad output value |
| pad_b_oe | output | 1 | Pin B pad output enable |
| pad_c_o | output | 1 | Pin C output |
| bus_ack_n_o | output | 1 | Bus acknowledge to the auxiliary bus logic |
| msi_irq | output | 1 | Modem status interrupt |

## Verification
A corrupted function-select or control register appears on the pads in the same cycle, because the pin outputs are combinational from those flops. Each table vector therefore exposes such a fault at once. A bad synchronizer or edge-tracker state shows up as a status bit that flips one edge early or late, or as a spurious delta after a mode switch. That is why the bench samples at the second and third edges after each pad change. A wrong delta-clear priority is only visible when a read coincides with a detected change, so the bench places one read exactly in that cycle.

// File: rtl/mpm_pkg.sv
`timescale 1ns/1ps
package mpm_pkg;
  localparam int unsigned REG_AW = 2;

  localparam logic [REG_AW-1:0] A_MCTL  = 2'd0;
  localparam logic [REG_AW-1:0] A_MSTAT = 2'd1;
  localparam logic [REG_AW-1:0] A_IEN   = 2'd2;
  localparam logic [REG_AW-1:0] A_PFN   = 2'd3;

  localparam int unsigned B_DTR  = 0;
  localparam int unsigned B_RTS  = 2;
  localparam int unsigned B_LOOP = 4;
  localparam int unsigned B_DDSR = 1;
  localparam int unsigned B_NDSR = 5;
  localparam int unsigned B_IEN  = 0;

  localparam int unsigned FN_W   = 2;
  localparam int unsigned N_PINS = 3;

  typedef enum logic [FN_W-1:0] {
    PF_AUX    = 2'b00,
    PF_CS     = 2'b01,
    PF_MODEM  = 2'b10,
    PF_MODEM2 = 2'b11
  } pin_fn_e;
endpackage

// File: rtl/mpm_regs.sv
`timescale 1ns/1ps
module mpm_regs
  import mpm_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] addr,
  input  logic              wr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     mctl_q,
  output logic [DW-1:0]     ien_q,
  output logic [DW-1:0]     pfn_q
);
  logic [DW-1:0] mctl_d, ien_d, pfn_d;
  logic          mctl_en, ien_en, pfn_en;

  always_comb begin
    mctl_en = wr && (addr == A_MCTL);
    ien_en  = wr && (addr == A_IEN);
    pfn_en  = wr && (addr == A_PFN);
    mctl_d  = mctl_en ? wdata : mctl_q;
    ien_d   = ien_en  ? wdata : ien_q;
    pfn_d   = pfn_en  ? wdata : pfn_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mctl_q <= '0;
      ien_q  <= '0;
      pfn_q  <= '0;
    end else begin
      mctl_q <= mctl_d;
      ien_q  <= ien_d;
      pfn_q  <= pfn_d;
    end
  end

  // R11: a write elsewhere leaves the control byte untouched
  p_mctl_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr != A_MCTL) |=> $stable(mctl_q));
endmodule

// File: rtl/mpm_dsr_track.sv
`timescale 1ns/1ps
module mpm_dsr_track #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pad_in,
  input  logic modem_en,
  input  logic clr,
  input  logic ien,
  output logic level,
  output logic delta,
  output logic irq
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;
  logic              delta_q, delta_d;
  logic              edge_seen;

  generate
    if (STAGES > 1) begin : g_chain
      assign sync_d = {sync_q[STAGES-2:0], pad_in};
    end else begin : g_single
      assign sync_d = pad_in;
    end
  endgenerate

  assign level     = sync_q[STAGES-1];
  assign edge_seen = modem_en && (level != prev_q);

  always_comb begin
    prev_d  = level;
    delta_d = (delta_q && !clr) || edge_seen;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '1;
      prev_q  <= 1'b1;
      delta_q <= 1'b0;
    end else begin
      sync_q  <= sync_d;
      prev_q  <= prev_d;
      delta_q <= delta_d;
    end
  end

  assign delta = delta_q;
  assign irq   = delta_q && ien;

  // R9: without a clearing read the flag is sticky
  p_delta_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (delta_q && !clr) |=> delta_q);
  // R9: a read with no coincident change clears the flag
  p_delta_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !edge_seen) |=> !delta_q);
  // R8: the flag only rises while the pin was in modem mode
  p_delta_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(delta_q) |-> $past(modem_en));
endmodule

// File: rtl/mpm_pin_mux.sv
`timescale 1ns/1ps
module mpm_pin_mux
  import mpm_pkg::*;
(
  input  logic [FN_W-1:0] fn_a,
  input  logic [FN_W-1:0] fn_b,
  input  logic [FN_W-1:0] fn_c,
  input  logic            rts_on,
  input  logic            dtr_on,
  input  logic            loop_on,
  input  logic            bus_req_n_i,
  input  logic [N_PINS-1:0] cs_n_i,
  input  logic            drv_n_i,
  input  logic            pad_b_i,
  output logic            pad_a_o,
  output logic            pad_c_o,
  output logic            pad_b_o,
  output logic            pad_b_oe,
  output logic            bus_ack_n_o,
  output logic            modem_b
);
  localparam int unsigned N_OUT = 2;

  function automatic logic pick(input logic [FN_W-1:0] f, input logic v_aux,
                                input logic v_cs, input logic v_mdm);
    logic r;
    case (f)
      PF_AUX:  r = v_aux;
      PF_CS:   r = v_cs;
      default: r = v_mdm;
    endcase
    return r;
  endfunction

  logic [N_OUT-1:0][FN_W-1:0] out_fn;
  logic [N_OUT-1:0]           out_aux, out_cs, out_mdm, out_pad;

  assign out_fn  = {fn_c, fn_a};
  assign out_aux = {drv_n_i, bus_req_n_i};
  assign out_cs  = {cs_n_i[2], cs_n_i[0]};
  assign out_mdm = {!dtr_on || loop_on, !rts_on || loop_on};

  generate
    for (genvar i = 0; i < N_OUT; i++) begin : g_out
      assign out_pad[i] = pick(out_fn[i], out_aux[i], out_cs[i], out_mdm[i]);
    end
  endgenerate

  assign pad_a_o = out_pad[0];
  assign pad_c_o = out_pad[1];

  always_comb begin
    pad_b_oe    = (fn_b == PF_CS);
    pad_b_o     = pad_b_oe ? cs_n_i[1] : 1'b1;
    bus_ack_n_o = (fn_b == PF_AUX) ? pad_b_i : 1'b1;
    modem_b     = fn_b[1];
  end
endmodule

// File: rtl/modem_pin_mux.sv
`timescale 1ns/1ps
module modem_pin_mux
  import mpm_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              bus_req_n_i,
  input  logic [2:0]        cs_n_i,
  input  logic              drv_n_i,
  output logic              pad_a_o,
  input  logic              pad_b_i,
  output logic              pad_b_o,
  output logic              pad_b_oe,
  output logic              pad_c_o,
  output logic              bus_ack_n_o,
  output logic              msi_irq
);
  localparam int unsigned RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_sync_q;
  logic                  rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[RST_STAGES-1];

  logic [DW-1:0] mctl_q, ien_q, pfn_q;
  logic          dsr_level, dsr_delta, modem_b, rd_clr;

  mpm_regs #(.DW(DW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .addr   (reg_addr),
    .wr     (reg_wr),
    .wdata  (reg_wdata),
    .mctl_q (mctl_q),
    .ien_q  (ien_q),
    .pfn_q  (pfn_q)
  );

  assign rd_clr = reg_rd && (reg_addr == A_MSTAT);

  mpm_dsr_track #(.STAGES(SYNC_STAGES)) u_dsr (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .pad_in   (pad_b_i),
    .modem_en (modem_b),
    .clr      (rd_clr),
    .ien      (ien_q[B_IEN]),
    .level    (dsr_level),
    .delta    (dsr_delta),
    .irq      (msi_irq)
  );

  mpm_pin_mux u_mux (
    .fn_a        (pfn_q[1:0]),
    .fn_b        (pfn_q[3:2]),
    .fn_c        (pfn_q[5:4]),
    .rts_on      (mctl_q[B_RTS]),
    .dtr_on      (mctl_q[B_DTR]),
    .loop_on     (mctl_q[B_LOOP]),
    .bus_req_n_i (bus_req_n_i),
    .cs_n_i      (cs_n_i),
    .drv_n_i     (drv_n_i),
    .pad_b_i     (pad_b_i),
    .pad_a_o     (pad_a_o),
    .pad_c_o     (pad_c_o),
    .pad_b_o     (pad_b_o),
    .pad_b_oe    (pad_b_oe),
    .bus_ack_n_o (bus_ack_n_o),
    .modem_b     (modem_b)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_MCTL:  reg_rdata = mctl_q;
      A_MSTAT: begin
        reg_rdata[B_NDSR] = modem_b && !dsr_level;
        reg_rdata[B_DDSR] = dsr_delta;
      end
      A_IEN:   reg_rdata = ien_q;
      default: reg_rdata = pfn_q;
    endcase
  end

  // R5: loop mode keeps modem outputs inactive
  p_loop_rts_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (pfn_q[1] && mctl_q[B_LOOP]) |-> pad_a_o);
  p_loop_dtr_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (pfn_q[5] && mctl_q[B_LOOP]) |-> pad_c_o);
  // R4: pin B drives only in chip-select mode
  p_padb_release_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (pfn_q[3:2] != PF_CS) |-> (!pad_b_oe && pad_b_o));
  // R10: interrupt needs both the flag and the enable
  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    msi_irq |-> (dsr_delta && ien_q[B_IEN]));
endmodule

// File: tb/modem_pin_mux_test.sv
`timescale 1ns/1ps
module modem_pin_mux_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] reg_addr;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_wdata, reg_rdata;
  logic       bus_req_n_i, drv_n_i, pad_b_i;
  logic [2:0] cs_n_i;
  logic       pad_a_o, pad_b_o, pad_b_oe, pad_c_o, bus_ack_n_o, msi_irq;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  modem_pin_mux uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_req_n_i(bus_req_n_i), .cs_n_i(cs_n_i), .drv_n_i(drv_n_i),
    .pad_a_o(pad_a_o), .pad_b_i(pad_b_i), .pad_b_o(pad_b_o),
    .pad_b_oe(pad_b_oe), .pad_c_o(pad_c_o), .bus_ack_n_o(bus_ack_n_o),
    .msi_irq(msi_irq)
  );

  // {fn[5:0], mctl[7:0], bus_req, cs[2:0], drv, pad_b, exp{a,c,oe,b_o,ack}}
  localparam int NV = 10;
  localparam logic [24:0] VEC [NV] = '{
    {6'b000000, 8'h00, 1'b0, 3'b111, 1'b1, 1'b0, 5'b01010},
    {6'b000000, 8'h00, 1'b1, 3'b000, 1'b0, 1'b1, 5'b10011},
    {6'b010101, 8'h00, 1'b1, 3'b010, 1'b1, 1'b0, 5'b00111},
    {6'b010101, 8'h05, 1'b0, 3'b101, 1'b0, 1'b1, 5'b11101},
    {6'b101010, 8'h05, 1'b0, 3'b000, 1'b0, 1'b0, 5'b00011},
    {6'b101010, 8'h01, 1'b0, 3'b000, 1'b0, 1'b0, 5'b10011},
    {6'b101010, 8'h04, 1'b0, 3'b000, 1'b0, 1'b0, 5'b01011},
    {6'b111111, 8'h15, 1'b0, 3'b000, 1'b0, 1'b0, 5'b11011},
    {6'b010010, 8'h05, 1'b1, 3'b011, 1'b1, 1'b0, 5'b00010},
    {6'b000000, 8'h15, 1'b0, 3'b111, 1'b0, 1'b0, 5'b00010}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    bus_req_n_i = 1'b1; cs_n_i = 3'b111; drv_n_i = 1'b1; pad_b_i = 1'b1;
    edges(3);
    rst_n = 1'b1;
    edges(3);

    // R6 reset state, R11 readback of zero
    for (int a = 0; a < 4; a++) begin
      peek(2'(a), d);
      chk("R6 reset register", {24'd0, d}, 32'h0);
    end
    bus_req_n_i = 1'b0; #1;
    chk("R6 pin A in bus mode after reset", {31'd0, pad_a_o}, 32'd0);
    bus_req_n_i = 1'b1;
    wr_reg(2'd3, 8'h22);
    #1 chk("R6 RTS/DTR inactive after reset", {30'd0, pad_a_o, pad_c_o}, 32'd3);

    // R11 readback of full bytes, status ignores writes
    wr_reg(2'd0, 8'hA5); peek(2'd0, d); chk("R11 control readback", {24'd0, d}, 32'hA5);
    wr_reg(2'd2, 8'h5A); peek(2'd2, d); chk("R11 enable readback", {24'd0, d}, 32'h5A);
    wr_reg(2'd3, 8'hC9); peek(2'd3, d); chk("R11 function readback", {24'd0, d}, 32'hC9);
    wr_reg(2'd3, 8'h00);
    wr_reg(2'd1, 8'hFF); peek(2'd1, d); chk("R11 status write ignored", {24'd0, d}, 32'h00);

    // R1 R2 R3 R4 R5 pin function table
    for (int i = 0; i < NV; i++) begin
      wr_reg(2'd3, {2'b00, VEC[i][24:19]});
      wr_reg(2'd0, VEC[i][18:11]);
      bus_req_n_i = VEC[i][10];
      cs_n_i      = VEC[i][9:7];
      drv_n_i     = VEC[i][6];
      pad_b_i     = VEC[i][5];
      #1 chk($sformatf("R1 R2 R3 R4 R5 vector %0d", i),
             {27'd0, pad_a_o, pad_c_o, pad_b_oe, pad_b_o, bus_ack_n_o},
             {27'd0, VEC[i][4:0]});
    end

    // DSR tracking: pin B modem, interrupt enabled, flag cleared
    pad_b_i = 1'b1;
    wr_reg(2'd0, 8'h00);
    wr_reg(2'd3, 8'h08);
    wr_reg(2'd2, 8'h01);
    edges(3);
    rd_reg(2'd1, d);
    peek(2'd1, d); chk("R9 flag cleared before test", {24'd0, d}, 32'h00);

    @(negedge clk); pad_b_i = 1'b0;
    edges(1); peek(2'd1, d); chk("R7 status one edge after change", {24'd0, d}, 32'h00);
    edges(1); peek(2'd1, d); chk("R7 inverted DSR at second edge", {24'd0, d}, 32'h20);
    edges(1); peek(2'd1, d); chk("R8 delta at third edge", {24'd0, d}, 32'h22);
    chk("R10 irq raised", {31'd0, msi_irq}, 32'd1);
    edges(5); chk("R10 irq held", {31'd0, msi_irq}, 32'd1);
    rd_reg(2'd1, d); chk("R9 read returns delta", {24'd0, d}, 32'h22);
    peek(2'd1, d); chk("R9 delta cleared by read", {24'd0, d}, 32'h20);
    chk("R10 irq dropped", {31'd0, msi_irq}, 32'd0);

    // R9 coincident read and change
    @(negedge clk); pad_b_i = 1'b1;
    edges(3); peek(2'd1, d); chk("R8 delta on rising pad", {24'd0, d}, 32'h02);
    @(negedge clk); pad_b_i = 1'b0;
    edges(1);
    rd_reg(2'd1, d);
    peek(2'd1, d); chk("R9 coincident change keeps delta", {24'd0, d}, 32'h22);
    rd_reg(2'd1, d);
    peek(2'd1, d); chk("R9 plain read clears", {24'd0, d}, 32'h20);

    // R8 ignored outside modem mode, no delta on entering it
    wr_reg(2'd3, 8'h00);
    @(negedge clk); pad_b_i = 1'b1;
    edges(5); peek(2'd1, d); chk("R8 pad ignored in bus mode", {24'd0, d}, 32'h00);
    chk("R10 no irq in bus mode", {31'd0, msi_irq}, 32'd0);
    chk("R4 ack follows pad", {31'd0, bus_ack_n_o}, 32'd1);
    wr_reg(2'd3, 8'h08);
    edges(3); peek(2'd1, d); chk("R8 no delta on mode entry", {24'd0, d}, 32'h00);

    // R10 enable gating
    wr_reg(2'd2, 8'h00);
    @(negedge clk); pad_b_i = 1'b0;
    edges(3); peek(2'd1, d); chk("R10 delta set with irq off", {24'd0, d}, 32'h22);
    chk("R10 irq masked", {31'd0, msi_irq}, 32'd0);
    wr_reg(2'd2, 8'h01);
    chk("R10 irq on enable", {31'd0, msi_irq}, 32'd1);

    // R6 asynchronous reset mid-run
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R6 irq cleared in reset", {31'd0, msi_irq}, 32'd0);
    peek(2'd3, d); chk("R6 function cleared in reset", {24'd0, d}, 32'h00);
    peek(2'd0, d); chk("R6 control cleared in reset", {24'd0, d}, 32'h00);
    edges(2); rst_n = 1'b1; edges(3);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule